// File: doc/BRIEF.md
# Vectored Interrupt Router

This block gathers up to 256 interrupt sources into a single pending array and delivers each one to a chosen core on a chosen parent interrupt line. Each source is set to be edge-sensitive or level-sensitive when the block is built. An edge source records a pending bit on its rising edge. A level source records a pending bit in every cycle it is high. Software then clears the recorded bits by writing ones back into the status words.

Every pending vector goes through three gates:
- a per-vector enable bit;
- a per-group byte, one per 32 vectors, that selects the parent line;
- a per-vector route byte that gives the destination node and a one-hot core mask.

A vector reaches core c on line k only when all three gates allow it and the route byte names this node. The whole array is also gated by a global enable pin.

All configuration and status go through a plain 64-bit register port. The port has a byte address, byte enables, a write strobe and a read strobe. Read data appears one cycle after the read strobe. There is no back-pressure: an access is taken in the cycle its strobe is high. The node-map and bounce regions are storage only and have no effect on delivery.

Top module: `vir_top`

## Requirements
- R1: After reset every register reads zero and every `core_irq` bit is low.
- R2: An edge vector sets its pending bit on a 0-to-1 source transition, and a held-high source does not set it again. A level vector sets its pending bit in every cycle its source is high. Vector n is bit n%64 of the status word at byte address 0x1800 + 8*(n/64).
- R3: A write to a status word clears exactly the pending bits written as one, and only inside byte lanes whose byte enable is set.
- R4: A pending set and a clear of the same bit in the same cycle leave the bit set.
- R5: Enable bit for vector v is bit v%32 of the 32-bit register at byte 0x1600 + 4*(v/32) (bit v of the 64-bit words from 0x1600). A zero enable keeps the vector off every output, while its pending bit is still recorded.
- R6: The route byte of vector v is at byte address 0x1c00 + v. Bits [3:0] are the one-hot core mask and bits [7:4] the node number. A vector whose node differs from the `NODE_ID` parameter drives no output.
- R7: The line-map byte of group g (vectors 32g..32g+31) is at byte 0x14c0 + g. Bit k selects line k, and the output for core c, line k is `core_irq[c*8+k]`.
- R8: While `route_en` is low, all `core_irq` bits are low one cycle later.
- R9: `core_irq` is registered: it reflects pending, enable, map and route state one clock edge after that state changes.
- R10: The node-map region (0x14a0, 32 bytes) and the bounce region (0x1680, 32 bytes) store written bytes under byte enables and read them back.
- R11: `bus_rdata` is updated on the clock edge that samples `bus_rd`. Unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| route_en | input | 1 | Global delivery enable |
| src_in | input | 256 | Interrupt source lines, one per vector |
| bus_addr | input | 16 | Byte address, 8-byte aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 8 | Byte enables for writes |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the cycle after `bus_rd` |
| core_irq | output | 32 | Per-core, per-line interrupt outputs, index core*8+line |

## Verification
The hardest case to reach is a source edge and a write-one-to-clear of the same bit landing on the same clock edge. The bench drives the source rise and the status write on the same falling edge, so both are sampled together, and then reads the word back. A second hard case is a level source that is still high during its clear. It is checked by clearing while the source is held and expecting the bit to survive. Byte-lane clears are checked by setting pending bits in two lanes and clearing with a single-lane enable.

// File: rtl/vir_pkg.sv
package vir_pkg;
  localparam int unsigned BUS_W      = 64;
  localparam int unsigned BUS_BYTES  = BUS_W / 8;
  localparam int unsigned ADDR_W     = 16;
  localparam logic [ADDR_W-1:0] BASE_NODEMAP = 16'h14a0;
  localparam logic [ADDR_W-1:0] BASE_LINEMAP = 16'h14c0;
  localparam logic [ADDR_W-1:0] BASE_ENABLE  = 16'h1600;
  localparam logic [ADDR_W-1:0] BASE_BOUNCE  = 16'h1680;
  localparam logic [ADDR_W-1:0] BASE_STATUS  = 16'h1800;
  localparam logic [ADDR_W-1:0] BASE_ROUTE   = 16'h1c00;

  typedef enum logic [2:0] {
    RG_NONE, RG_NODEMAP, RG_LINEMAP, RG_ENABLE, RG_BOUNCE, RG_STATUS, RG_ROUTE
  } region_e;

  function automatic logic [BUS_W-1:0] lane_mask(input logic [BUS_BYTES-1:0] be);
    logic [BUS_W-1:0] m;
    for (int b = 0; b < BUS_BYTES; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/vir_regbank.sv
module vir_regbank
  import vir_pkg::*;
#(
  parameter int unsigned NWORDS = 4,
  localparam int unsigned IW = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IW-1:0]           word_idx,
  input  logic [BUS_W-1:0]        wdata,
  input  logic [BUS_BYTES-1:0]    be,
  output logic [NWORDS*BUS_W-1:0] flat,
  output logic [BUS_W-1:0]        rdata
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar b = 0; b < BUS_BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)
          flat[w*BUS_W + b*8 +: 8] <= '0;
        else if (wr_en && (int'(word_idx) == w) && be[b])
          flat[w*BUS_W + b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWORDS; w++)
      if (int'(word_idx) == w) rdata = flat[w*BUS_W +: BUS_W];
  end
endmodule

// File: rtl/vir_pending.sv
module vir_pending #(
  parameter int unsigned NVEC = 256,
  parameter logic [NVEC-1:0] LEVEL_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] src,
  input  logic [NVEC-1:0] clr_v,
  output logic [NVEC-1:0] pend
);
  logic [NVEC-1:0] src_q;
  logic [NVEC-1:0] set_v;

  for (genvar v = 0; v < NVEC; v++) begin : g_src
    if (LEVEL_MASK[v]) begin : g_level
      assign set_v[v] = src[v];
    end else begin : g_edge
      assign set_v[v] = src[v] & ~src_q[v];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
    end else begin
      src_q <= src;
      pend  <= (pend & ~clr_v) | set_v;
    end
  end

  // R4: a set request always leaves its bit pending, even against a clear
  p_set_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((pend & $past(set_v)) == $past(set_v)));

  // R3: a clear without a competing set leaves the bit low
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v != '0) |=> ((pend & $past(clr_v & ~set_v)) == '0));
endmodule

// File: rtl/vir_dispatch.sv
module vir_dispatch #(
  parameter int unsigned NVEC   = 256,
  parameter int unsigned GROUP  = 32,
  parameter int unsigned CORES  = 4,
  parameter int unsigned LINES  = 8,
  parameter int unsigned NODE_W = 4,
  parameter logic [NODE_W-1:0] NODE_ID = '0,
  localparam int unsigned NGRP = NVEC / GROUP,
  localparam int unsigned RB   = CORES + NODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glb_en,
  input  logic [NVEC-1:0]       pend,
  input  logic [NVEC-1:0]       enable,
  input  logic [NGRP*8-1:0]     linemap,
  input  logic [NVEC*RB-1:0]    route,
  output logic [CORES*LINES-1:0] core_irq
);
  logic [NVEC-1:0]        live;
  logic [NVEC-1:0]        local_v;
  logic [CORES*LINES-1:0] hit;

  assign live = pend & enable;

  for (genvar v = 0; v < NVEC; v++) begin : g_node
    assign local_v[v] = (route[v*RB + CORES +: NODE_W] == NODE_ID);
  end

  always_comb begin
    hit = '0;
    for (int v = 0; v < NVEC; v++) begin
      if (live[v] && local_v[v]) begin
        for (int c = 0; c < CORES; c++) begin
          for (int k = 0; k < LINES; k++) begin
            if (route[v*RB + c] && linemap[(v/GROUP)*8 + k])
              hit[c*LINES + k] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      core_irq <= '0;
    else if (glb_en) core_irq <= hit;
    else             core_irq <= '0;
  end

  // R8: global enable low silences every output on the next edge
  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (core_irq == '0));

  // R5: with nothing both pending and enabled, no output rises
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> (core_irq == '0));
endmodule

// File: rtl/vir_top.sv
module vir_top
  import vir_pkg::*;
#(
  parameter int unsigned NVEC   = 256,
  parameter int unsigned GROUP  = 32,
  parameter int unsigned CORES  = 4,
  parameter int unsigned LINES  = 8,
  parameter int unsigned NODE_W = 4,
  parameter logic [NODE_W-1:0] NODE_ID = '0,
  parameter logic [NVEC-1:0] LEVEL_MASK = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    route_en,
  input  logic [NVEC-1:0]         src_in,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [BUS_BYTES-1:0]    bus_be,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  output logic [CORES*LINES-1:0]  core_irq
);
  localparam int unsigned RB     = CORES + NODE_W;
  localparam int unsigned NGRP   = NVEC / GROUP;
  localparam int unsigned W_VEC  = NVEC / BUS_W;
  localparam int unsigned W_MAP  = (NGRP * 8 + BUS_W - 1) / BUS_W;
  localparam int unsigned W_RT   = (NVEC * RB) / BUS_W;
  localparam int unsigned W_NODE = 4;
  localparam int unsigned IW_VEC = (W_VEC > 1) ? $clog2(W_VEC) : 1;
  localparam int unsigned IW_MAP = (W_MAP > 1) ? $clog2(W_MAP) : 1;
  localparam int unsigned IW_RT  = (W_RT > 1) ? $clog2(W_RT) : 1;
  localparam int unsigned IW_ND  = (W_NODE > 1) ? $clog2(W_NODE) : 1;

  function automatic logic in_rng(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] base,
                                  input int unsigned nw);
    return (a >= base) && (32'(a) < 32'(base) + nw * BUS_BYTES);
  endfunction

  region_e rg;
  logic [ADDR_W-1:0] off;
  logic [2:0] addr_lo_unused;
  assign addr_lo_unused = bus_addr[2:0];

  always_comb begin
    rg  = RG_NONE;
    off = '0;
    if (in_rng(bus_addr, BASE_NODEMAP, W_NODE)) begin
      rg = RG_NODEMAP; off = bus_addr - BASE_NODEMAP;
    end else if (in_rng(bus_addr, BASE_LINEMAP, W_MAP)) begin
      rg = RG_LINEMAP; off = bus_addr - BASE_LINEMAP;
    end else if (in_rng(bus_addr, BASE_ENABLE, W_VEC)) begin
      rg = RG_ENABLE;  off = bus_addr - BASE_ENABLE;
    end else if (in_rng(bus_addr, BASE_BOUNCE, W_VEC)) begin
      rg = RG_BOUNCE;  off = bus_addr - BASE_BOUNCE;
    end else if (in_rng(bus_addr, BASE_STATUS, W_VEC)) begin
      rg = RG_STATUS;  off = bus_addr - BASE_STATUS;
    end else if (in_rng(bus_addr, BASE_ROUTE, W_RT)) begin
      rg = RG_ROUTE;   off = bus_addr - BASE_ROUTE;
    end
  end

  logic [ADDR_W-4:0] widx;
  assign widx = off[ADDR_W-1:3];

  logic [W_NODE*BUS_W-1:0] nodemap_unused;
  logic [W_VEC*BUS_W-1:0]  bounce_unused;
  logic [W_VEC*BUS_W-1:0]  en_flat;
  logic [W_MAP*BUS_W-1:0]  map_flat;
  logic [W_RT*BUS_W-1:0]   rt_flat;
  logic [BUS_W-1:0] rd_node, rd_map, rd_en, rd_bnc, rd_rt, rd_st;

  vir_regbank #(.NWORDS(W_NODE)) u_nodemap (
    .clk, .rst_n, .wr_en(bus_wr && rg == RG_NODEMAP), .word_idx(widx[IW_ND-1:0]),
    .wdata(bus_wdata), .be(bus_be), .flat(nodemap_unused), .rdata(rd_node));

  vir_regbank #(.NWORDS(W_MAP)) u_linemap (
    .clk, .rst_n, .wr_en(bus_wr && rg == RG_LINEMAP), .word_idx(widx[IW_MAP-1:0]),
    .wdata(bus_wdata), .be(bus_be), .flat(map_flat), .rdata(rd_map));

  vir_regbank #(.NWORDS(W_VEC)) u_enable (
    .clk, .rst_n, .wr_en(bus_wr && rg == RG_ENABLE), .word_idx(widx[IW_VEC-1:0]),
    .wdata(bus_wdata), .be(bus_be), .flat(en_flat), .rdata(rd_en));

  vir_regbank #(.NWORDS(W_VEC)) u_bounce (
    .clk, .rst_n, .wr_en(bus_wr && rg == RG_BOUNCE), .word_idx(widx[IW_VEC-1:0]),
    .wdata(bus_wdata), .be(bus_be), .flat(bounce_unused), .rdata(rd_bnc));

  vir_regbank #(.NWORDS(W_RT)) u_route (
    .clk, .rst_n, .wr_en(bus_wr && rg == RG_ROUTE), .word_idx(widx[IW_RT-1:0]),
    .wdata(bus_wdata), .be(bus_be), .flat(rt_flat), .rdata(rd_rt));

  // status: write-one-to-clear under byte enables
  logic [NVEC-1:0] pend;
  logic [NVEC-1:0] clr_v;
  logic [BUS_W-1:0] wmask;
  assign wmask = bus_wdata & lane_mask(bus_be);

  for (genvar w = 0; w < W_VEC; w++) begin : g_clr
    assign clr_v[w*BUS_W +: BUS_W] =
      (bus_wr && rg == RG_STATUS && int'(widx) == w) ? wmask : '0;
  end

  always_comb begin
    rd_st = '0;
    for (int w = 0; w < W_VEC; w++)
      if (int'(widx) == w) rd_st = pend[w*BUS_W +: BUS_W];
  end

  vir_pending #(.NVEC(NVEC), .LEVEL_MASK(LEVEL_MASK)) u_pend (
    .clk, .rst_n, .src(src_in), .clr_v(clr_v), .pend(pend));

  vir_dispatch #(.NVEC(NVEC), .GROUP(GROUP), .CORES(CORES), .LINES(LINES),
                 .NODE_W(NODE_W), .NODE_ID(NODE_ID)) u_disp (
    .clk, .rst_n, .glb_en(route_en), .pend(pend), .enable(en_flat[NVEC-1:0]),
    .linemap(map_flat[NGRP*8-1:0]), .route(rt_flat[NVEC*RB-1:0]), .core_irq(core_irq));

  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    unique case (rg)
      RG_NODEMAP: rd_mux = rd_node;
      RG_LINEMAP: rd_mux = rd_map;
      RG_ENABLE:  rd_mux = rd_en;
      RG_BOUNCE:  rd_mux = rd_bnc;
      RG_STATUS:  rd_mux = rd_st;
      RG_ROUTE:   rd_mux = rd_rt;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R11: a read of an unmapped address returns zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rg == RG_NONE) |=> (bus_rdata == '0));

  // R11: read data only moves on a read strobe
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_vir_top.sv
module sim_vir_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [255:0] LVL = {{64{1'b1}}, {192{1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic route_en = 1'b0;
  logic [255:0] src_in = '0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_be = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [31:0] core_irq;

  int n_cmp = 0, n_bad = 0;
  logic rd_seen = 1'b0;
  logic [63:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vir_top #(.NODE_ID(4'd2), .LEVEL_MASK(LVL)) u0 (
    .clk, .rst_n, .route_en, .src_in, .bus_addr, .bus_wr, .bus_rd,
    .bus_be, .bus_wdata, .bus_rdata, .core_irq);

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pops the expected read data as each read completes
  always @(negedge clk) begin
    if (rd_seen) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [15:0] a, input logic [63:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [31:0] e, input string t);
    n_cmp++;
    if (core_irq !== e) begin
      n_bad++;
      $display("FAIL %s: actual core_irq %h expected %h", t, core_irq, e);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk_irq(32'h0, "R1 irq after reset");
    rd_exp(16'h1600, 64'h0, "R1 enable reset");
    rd_exp(16'h1c00, 64'h0, "R1 route reset");
    rd_exp(16'h1800, 64'h0, "R1 status reset");
    rd_exp(16'h14c0, 64'h0, "R1 linemap reset");

    // R10 storage-only regions under byte enables
    wr(16'h14a0, 64'h1122334455667788, 8'h0F);
    rd_exp(16'h14a0, 64'h0000000055667788, "R10 nodemap lanes");
    wr(16'h1688, 64'hdeadbeefcafef00d, 8'hFF);
    rd_exp(16'h1688, 64'hdeadbeefcafef00d, "R10 bounce readback");

    // vector 5 -> node 2, core 1, group 0 on line 3
    route_en = 1'b1;
    wr(16'h1600, 64'h1 << 5, 8'hFF);
    wr(16'h1c00, 64'h22 << 40, 8'h20);
    wr(16'h14c0, 64'h08, 8'h01);
    rd_exp(16'h1c00, 64'h22 << 40, "R6 route byte lane");
    @(negedge clk) src_in[5] = 1'b1;
    tick(2);
    chk_irq(32'h1 << 11, "R7 core1 line3");
    rd_exp(16'h1800, 64'h1 << 5, "R2 edge sets pending");

    // R3 clear; held edge source does not re-set
    wr(16'h1800, 64'h1 << 5, 8'hFF);
    tick(1);
    chk_irq(32'h0, "R3 irq after clear");
    rd_exp(16'h1800, 64'h0, "R2 held edge no reset");
    src_in[5] = 1'b0;

    // R4 set and clear on same edge
    @(negedge clk);
    src_in[6] = 1'b1;
    bus_addr = 16'h1800; bus_wdata = 64'h1 << 6; bus_be = 8'hFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_exp(16'h1800, 64'h1 << 6, "R4 set beats clear");
    wr(16'h1800, 64'h1 << 6, 8'hFF);
    rd_exp(16'h1800, 64'h0, "R4 later clear");
    src_in[6] = 1'b0;

    // vector 40: group 1 line 0, core 0, masked at first
    wr(16'h14c0, 64'h0108, 8'h03);
    wr(16'h1c28, 64'h21, 8'h01);
    @(negedge clk) src_in[40] = 1'b1;
    tick(2);
    chk_irq(32'h0, "R5 masked vector silent");
    rd_exp(16'h1800, 64'h1 << 40, "R5 masked still pending");
    wr(16'h1600, 64'h1 << 40, 8'h20);
    chk_irq(32'h0, "R9 not yet registered");
    tick(1);
    chk_irq(32'h1, "R9 one edge after enable");

    // R8 global gate
    route_en = 1'b0;
    tick(1);
    chk_irq(32'h0, "R8 gate off");
    route_en = 1'b1;
    tick(1);
    chk_irq(32'h1, "R8 gate on");

    // R6 foreign node, then all four cores
    wr(16'h1c28, 64'h31, 8'h01);
    tick(1);
    chk_irq(32'h0, "R6 foreign node ignored");
    wr(16'h1c28, 64'h2F, 8'h01);
    tick(1);
    chk_irq(32'h01010101, "R6 four-core mask");

    // R3 byte-lane clear
    @(negedge clk) begin src_in[0] = 1'b1; src_in[8] = 1'b1; end
    tick(2);
    wr(16'h1800, 64'hFFFFFFFFFFFFFFFF, 8'h01);
    rd_exp(16'h1800, (64'h1 << 8) | (64'h1 << 40), "R3 lane-limited clear");
    wr(16'h1800, 64'hFFFFFFFFFFFFFFFF, 8'hFF);
    rd_exp(16'h1800, 64'h0, "R3 full clear");

    // R2 level vector 200
    @(negedge clk) src_in[200] = 1'b1;
    tick(2);
    rd_exp(16'h1818, 64'h1 << 8, "R2 level sets");
    wr(16'h1818, 64'h1 << 8, 8'hFF);
    rd_exp(16'h1818, 64'h1 << 8, "R2 level re-sets while high");
    src_in[200] = 1'b0;
    tick(1);
    wr(16'h1818, 64'h1 << 8, 8'hFF);
    rd_exp(16'h1818, 64'h0, "R2 level clear after drop");

    // R11 unmapped access
    rd_exp(16'h1000, 64'h0, "R11 unmapped read");
    wr(16'h1000, 64'hFFFFFFFFFFFFFFFF, 8'hFF);
    rd_exp(16'h1600, (64'h1 << 5) | (64'h1 << 40), "R11 unmapped write ignored");

    tick(3);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 reads left: actual %0d expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule